// File: doc/BRIEF.md
# Posted Write Bus Drainer

This block is the initiator-side engine that moves posted memory writes from an internal queue out onto a parallel shared bus of the PCI kind. The queue hands it a stream of words. An address word, marked by a flag, opens each burst and carries the start byte address and the bus command. Data words follow it, each with its byte enables, and the last data word of the burst carries an end-of-burst mark. The engine asks for the bus as soon as an address word sits at the head of the queue. It does not wait for the rest of the burst to arrive.

The engine starts a transaction only when the arbiter grants the bus and no other master is using it. It drives one address phase and then streams data phases from the queue head. A DWORD leaves the queue only in a clock where both the initiator-ready and target-ready strobes are active. If the queue has run dry in the middle of a burst, the engine inserts master wait states instead of ending the burst early. If the target disconnects, the engine steps off the bus for one clock and asks for it again. It then resumes at the address of the first DWORD not yet delivered. All bus strobes are active low.

Top module: `pwd_drainer`

## Requirements
- R1: While reset is active and right after it, `req_n`, `frame_n` and `irdy_n` are high, and `ad_oe` and `q_pop` are low.
- R2: When the engine is idle and the head word is valid with `q_addr_flag`=1, the engine pops that word in the same clock, keeping `q_data` as the byte address and `q_be` as the command. `req_n` goes low from the next clock, even if no data word is valid yet.
- R3: `frame_n` first goes low (address phase) only in the clock after an edge where `req_n`, `gnt_n`, `frame_in_n` and `irdy_in_n` were sampled as low, low, high and high. `req_n` is high again in that address-phase clock.
- R4: The address phase lasts exactly one clock, with `ad_out` equal to the address and `cbe_out` equal to the command. In each later clock where `irdy_n` is low, `ad_out` and `cbe_out` equal the head word's `q_data` and `q_be`.
- R5: A data word is popped only in a clock where `irdy_n` and `trdy_n` are both low. Each such pop advances the burst address by 4 bytes.
- R6: During the data phases, `irdy_n` is low exactly when the head word is a valid data word. While the queue is empty before the end mark, `irdy_n` is high and `frame_n` stays low.
- R7: When the valid head word carries `q_last`=1, `frame_n` is high while `irdy_n` is low. Once that word transfers, the engine releases the bus and returns to idle.
- R8: If `stop_n` is sampled low in a data phase that does not complete the last word, the next clock has `frame_n` and `irdy_n` high and `ad_oe` low. `req_n` is low from the clock after that. The new address phase carries the start address plus 4 times the number of DWORDs already delivered.
- R9: `ad_oe` is high exactly in the address phase and the data phases, and it rises only together with a low `frame_n` and a high `req_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| q_valid | input | 1 | Queue head word is valid |
| q_addr_flag | input | 1 | Head word is an address word (1) or data word (0) |
| q_last | input | 1 | Head data word ends the burst |
| q_data | input | BUS_W | Head word: byte address or write data |
| q_be | input | BE_W | Head word: command or byte enables (active high) |
| q_pop | output | 1 | Head word consumed this clock |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_in_n | input | 1 | Observed bus frame line |
| irdy_in_n | input | 1 | Observed bus initiator-ready line |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| frame_n | output | 1 | Frame driven by this engine |
| irdy_n | output | 1 | Initiator ready driven by this engine |
| ad_oe | output | 1 | Enable for address/data and command/byte-enable drivers |
| ad_out | output | BUS_W | Address/data value |
| cbe_out | output | BE_W | Command or byte enables |

## Verification
Some properties are checked on every cycle. A new frame must follow a sampled grant on an idle bus, and the request must be off by then. The address phase is a single clock. A pop in a data phase needs both ready strobes. An empty queue mid-burst means a wait state with frame still held. Frame is never released without initiator ready, and a disconnect gives a one-clock release followed by a fresh request. Only the bench scenarios can show end-to-end ordering: that every queued DWORD reaches the bus once, in order, with the right address after a disconnect and re-arbitration, and that trickling input, late grants, busy buses and slow targets give exactly the expected strobe sequence.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } pwd_state_e;

  // The shared bus counts as free when neither frame nor initiator-ready is driven.
  function automatic logic bus_free(input logic frame_line_n, input logic irdy_line_n);
    return frame_line_n & irdy_line_n;
  endfunction
endpackage

// File: rtl/pwd_fsm.sv
module pwd_fsm
  import pwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       head_is_addr,
  input  logic       grant_ok,
  input  logic       xfer,
  input  logic       last_xfer,
  input  logic       stop_seen,
  output pwd_state_e state
);
  pwd_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (head_is_addr) nxt = ST_ARB;
      ST_ARB:  if (grant_ok) nxt = ST_ADDR;
      ST_ADDR: nxt = ST_DATA;
      ST_DATA: begin
        if (last_xfer)      nxt = ST_IDLE;
        else if (stop_seen) nxt = ST_TURN;
      end
      ST_TURN: nxt = ST_ARB;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwd_addr.sv
module pwd_addr #(
  parameter int BUS_W = 32,
  parameter int BE_W  = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [BUS_W-1:0] load_addr,
  input  logic [BE_W-1:0]  load_cmd,
  output logic [BUS_W-1:0] addr_q,
  output logic [BE_W-1:0]  cmd_q
);
  localparam int STEP = BE_W;

  function automatic logic [BUS_W-1:0] next_word(input logic [BUS_W-1:0] a);
    return a + BUS_W'(STEP);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      cmd_q  <= load_cmd;
    end else if (advance) begin
      addr_q <= next_word(addr_q);
    end
  end
endmodule

// File: rtl/pwd_drive.sv
module pwd_drive
  import pwd_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int BE_W  = BUS_W / 8
) (
  input  pwd_state_e       state,
  input  logic             q_valid,
  input  logic             q_addr_flag,
  input  logic             q_last,
  input  logic [BUS_W-1:0] q_data,
  input  logic [BE_W-1:0]  q_be,
  input  logic [BUS_W-1:0] addr_q,
  input  logic [BE_W-1:0]  cmd_q,
  input  logic             trdy_n,
  output logic             req_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic             ad_oe,
  output logic [BUS_W-1:0] ad_out,
  output logic [BE_W-1:0]  cbe_out,
  output logic             xfer
);
  logic in_addr, in_data, head_data;

  always_comb begin
    in_addr   = (state == ST_ADDR);
    in_data   = (state == ST_DATA);
    head_data = q_valid && !q_addr_flag;
    req_n     = !(state == ST_ARB);
    frame_n   = !(in_addr || (in_data && !(head_data && q_last)));
    irdy_n    = !(in_data && head_data);
    ad_oe     = in_addr || in_data;
    xfer      = !irdy_n && !trdy_n;
    ad_out    = '0;
    cbe_out   = '0;
    if (in_addr) begin
      ad_out  = addr_q;
      cbe_out = cmd_q;
    end else if (in_data) begin
      ad_out  = q_data;
      cbe_out = q_be;
    end
  end
endmodule

// File: rtl/pwd_drainer.sv
module pwd_drainer
  import pwd_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int BE_W  = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_valid,
  input  logic             q_addr_flag,
  input  logic             q_last,
  input  logic [BUS_W-1:0] q_data,
  input  logic [BE_W-1:0]  q_be,
  output logic             q_pop,
  output logic             req_n,
  input  logic             gnt_n,
  input  logic             frame_in_n,
  input  logic             irdy_in_n,
  input  logic             trdy_n,
  input  logic             stop_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic             ad_oe,
  output logic [BUS_W-1:0] ad_out,
  output logic [BE_W-1:0]  cbe_out
);
  pwd_state_e       state;
  logic             take_addr, grant_ok, xfer, last_xfer;
  logic             addr_phase, data_phase;
  logic [BUS_W-1:0] addr_q;
  logic [BE_W-1:0]  cmd_q;

  assign addr_phase = (state == ST_ADDR);
  assign data_phase = (state == ST_DATA);
  assign take_addr  = (state == ST_IDLE) && q_valid && q_addr_flag;
  assign grant_ok   = !gnt_n && bus_free(frame_in_n, irdy_in_n);
  assign last_xfer  = xfer && q_last;
  assign q_pop      = take_addr || xfer;

  pwd_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_is_addr (q_valid && q_addr_flag),
    .grant_ok     (grant_ok),
    .xfer         (xfer),
    .last_xfer    (last_xfer),
    .stop_seen    (!stop_n),
    .state        (state)
  );

  pwd_addr #(.BUS_W(BUS_W), .BE_W(BE_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_addr),
    .advance   (xfer),
    .load_addr (q_data),
    .load_cmd  (q_be),
    .addr_q    (addr_q),
    .cmd_q     (cmd_q)
  );

  pwd_drive #(.BUS_W(BUS_W), .BE_W(BE_W)) u_drive (
    .state       (state),
    .q_valid     (q_valid),
    .q_addr_flag (q_addr_flag),
    .q_last      (q_last),
    .q_data      (q_data),
    .q_be        (q_be),
    .addr_q      (addr_q),
    .cmd_q       (cmd_q),
    .trdy_n      (trdy_n),
    .req_n       (req_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .ad_oe       (ad_oe),
    .ad_out      (ad_out),
    .cbe_out     (cbe_out),
    .xfer        (xfer)
  );
endmodule

// File: rtl/pwd_drainer_chk.sv
module pwd_drainer_chk (
  input logic clk,
  input logic rst_n,
  input logic q_valid,
  input logic q_last,
  input logic q_pop,
  input logic req_n,
  input logic gnt_n,
  input logic frame_in_n,
  input logic irdy_in_n,
  input logic trdy_n,
  input logic stop_n,
  input logic frame_n,
  input logic irdy_n,
  input logic ad_oe,
  input logic addr_phase,
  input logic data_phase,
  input logic xfer
);
  p_start_on_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(!req_n && !gnt_n && frame_in_n && irdy_in_n));

  p_req_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> req_n);

  p_single_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> data_phase);

  p_pop_needs_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && data_phase) |-> (!irdy_n && !trdy_n));

  p_wait_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !q_valid) |-> (irdy_n && !frame_n));

  p_last_keeps_irdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && frame_n) |-> !irdy_n);

  p_stop_backoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !stop_n && !(xfer && q_last)) |=> (frame_n && irdy_n && !ad_oe) ##1 !req_n);

  p_drive_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> (!frame_n && req_n));
endmodule

bind pwd_drainer pwd_drainer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_valid    (q_valid),
  .q_last     (q_last),
  .q_pop      (q_pop),
  .req_n      (req_n),
  .gnt_n      (gnt_n),
  .frame_in_n (frame_in_n),
  .irdy_in_n  (irdy_in_n),
  .trdy_n     (trdy_n),
  .stop_n     (stop_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .ad_oe      (ad_oe),
  .addr_phase (addr_phase),
  .data_phase (data_phase),
  .xfer       (xfer)
);

// File: tb/sim_pwd_drainer.sv
module sim_pwd_drainer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        q_valid, q_addr_flag, q_last;
  logic [31:0] q_data;
  logic [3:0]  q_be;
  logic        q_pop, req_n, gnt_n, frame_in_n, irdy_in_n, trdy_n, stop_n;
  logic        frame_n, irdy_n, ad_oe;
  logic [31:0] ad_out;
  logic [3:0]  cbe_out;

  pwd_drainer u0 (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_addr_flag(q_addr_flag),
    .q_last(q_last), .q_data(q_data), .q_be(q_be), .q_pop(q_pop), .req_n(req_n),
    .gnt_n(gnt_n), .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad_oe(ad_oe),
    .ad_out(ad_out), .cbe_out(cbe_out)
  );

  typedef struct {
    logic        f;
    logic [31:0] d;
    logic [3:0]  be;
    logic        l;
  } ent_t;
  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
  } dw_t;

  ent_t fifo[$];
  dw_t  expect_q[$];
  int   vis, gap, gap_cnt;
  int   gnt_wait, busy_left, trdy_mode, stop_at;
  int   req_cycles, burst_xfers, cyc;
  int   tests, fails;
  // behavioural model: 0 idle, 1 asking, 2 address, 3 data, 4 back-off
  int          ph;
  logic [31:0] maddr, obs_addr;
  logic [3:0]  mcmd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic        hv, hf, hl, e_req, e_frame, e_irdy, e_oe, e_pop, moved;
    logic [31:0] hd;
    logic [3:0]  hbe;
    dw_t         dw;
    @(negedge clk);
    cyc++;
    if (gap > 0 && vis < fifo.size()) begin
      gap_cnt++;
      if (gap_cnt >= gap) begin vis++; gap_cnt = 0; end
    end
    hv = (vis > 0);
    hf = hv ? fifo[0].f : 1'b0;
    hl = hv ? fifo[0].l : 1'b0;
    hd = hv ? fifo[0].d : 32'h0bad0bad;
    hbe = hv ? fifo[0].be : 4'h0;
    q_valid = hv; q_addr_flag = hf; q_last = hl; q_data = hd; q_be = hbe;
    if (ph == 1) req_cycles++; else req_cycles = 0;
    gnt_n = !(ph == 1 && req_cycles > gnt_wait);
    if (busy_left > 0) begin frame_in_n = 1'b0; busy_left--; end
    else frame_in_n = 1'b1;
    irdy_in_n = 1'b1;
    trdy_n = (trdy_mode == 1) ? cyc[0] : 1'b0;
    stop_n = 1'b1;
    if (ph == 3 && stop_at >= 0 && burst_xfers == stop_at) begin
      stop_n = 1'b0; trdy_n = 1'b1; stop_at = -1;
    end
    #1;
    e_req   = !(ph == 1);
    e_frame = !(ph == 2 || (ph == 3 && !(hv && !hf && hl)));
    e_irdy  = !(ph == 3 && hv && !hf);
    e_oe    = (ph == 2 || ph == 3);
    moved   = !e_irdy && !trdy_n;
    e_pop   = (ph == 0 && hv && hf) || moved;
    chk("R2 req_n", 32'(req_n), 32'(e_req));
    chk("R3 frame_n", 32'(frame_n), 32'(e_frame));
    chk("R6 irdy_n", 32'(irdy_n), 32'(e_irdy));
    chk("R9 ad_oe", 32'(ad_oe), 32'(e_oe));
    chk("R5 q_pop", 32'(q_pop), 32'(e_pop));
    if (ph == 2) begin
      chk("R4 address", ad_out, maddr);
      chk("R4 command", 32'(cbe_out), 32'(mcmd));
      obs_addr = ad_out;
    end
    if (!e_irdy) begin
      chk("R4 data", ad_out, hd);
      chk("R4 byte enables", 32'(cbe_out), 32'(hbe));
    end
    if (ph == 3 && !irdy_n && !trdy_n) begin
      if (expect_q.size() == 0) chk("R5 unexpected transfer", 32'd1, 32'd0);
      else begin
        dw = expect_q.pop_front();
        chk("R8 word address", obs_addr, dw.a);
        chk("R7 delivered data", ad_out, dw.d);
        obs_addr = obs_addr + 32'd4;
      end
    end
    case (ph)
      0: if (hv && hf) begin maddr = hd; mcmd = hbe; ph = 1; end
      1: if (!gnt_n && frame_in_n && irdy_in_n) begin ph = 2; burst_xfers = 0; end
      2: ph = 3;
      3: begin
        if (moved) begin maddr = maddr + 32'd4; burst_xfers++; end
        if (moved && hl) ph = 0;
        else if (!stop_n) ph = 4;
      end
      default: ph = 1;
    endcase
    if (e_pop) begin void'(fifo.pop_front()); vis--; end
  endtask

  task automatic run(input int gw, input int busy, input int tm, input int st,
                     input int gp, input logic [31:0] base, input int n);
    gnt_wait = gw; busy_left = busy; trdy_mode = tm; stop_at = st;
    fifo.push_back('{f: 1'b1, d: base, be: 4'b0111, l: 1'b0});
    for (int i = 0; i < n; i++) begin
      logic [31:0] v;
      v = base ^ (32'h01010101 * (i + 1)) ^ 32'hA5000000;
      fifo.push_back('{f: 1'b0, d: v, be: 4'(15 - (i % 4)), l: (i == n - 1)});
      expect_q.push_back('{a: base + 32'(4 * i), d: v});
    end
    gap = gp; gap_cnt = 0;
    vis = (gp == 0) ? fifo.size() : 1;
    while (!(ph == 0 && fifo.size() == 0)) step();
    repeat (2) step();
    chk("R7 all words delivered", 32'(expect_q.size()), 32'd0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; cyc = 0; ph = 0; vis = 0; gap = 0; gap_cnt = 0;
    gnt_wait = 0; busy_left = 0; trdy_mode = 0; stop_at = -1;
    req_cycles = 0; burst_xfers = 0; maddr = '0; mcmd = '0; obs_addr = '0;
    rst_n = 1'b0; q_valid = 1'b0; q_addr_flag = 1'b0; q_last = 1'b0;
    q_data = '0; q_be = '0; gnt_n = 1'b1; frame_in_n = 1'b1; irdy_in_n = 1'b1;
    trdy_n = 1'b1; stop_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 req_n", 32'(req_n), 32'd1);
    chk("R1 frame_n", 32'(frame_n), 32'd1);
    chk("R1 irdy_n", 32'(irdy_n), 32'd1);
    chk("R1 ad_oe", 32'(ad_oe), 32'd0);
    chk("R1 q_pop", 32'(q_pop), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", 32'({req_n, frame_n, irdy_n, ad_oe}), 32'b1110);
    run(0, 0, 0, -1, 0, 32'h0000_1000, 3);  // R2 R3 R4 basic burst
    run(0, 0, 0, -1, 3, 32'h0000_2000, 4);  // R2 R6 trickling data
    run(4, 3, 0, -1, 0, 32'h0000_3000, 2);  // R3 late grant, busy bus
    run(0, 0, 1, -1, 0, 32'h0000_4000, 4);  // R5 target wait states
    run(0, 0, 0, 2, 0, 32'h0000_5000, 5);   // R8 disconnect mid burst
    run(0, 0, 0, -1, 0, 32'h0000_6000, 1);  // R7 single word burst
    run(1, 2, 1, 0, 2, 32'h0000_7000, 3);   // R8 disconnect before any word
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule